// File: doc/BRIEF.md
# SDRAM Bank-State Command Legality Checker

This block sits beside a mobile double-data-rate SDRAM command bus and watches one decoded command per clock. It keeps a model of each bank's state and of the device-wide protected windows that follow mode-register reads and writes. It raises a one-cycle violation flag with a reason code whenever a command is not allowed in the state it meets. A command that violates a rule leaves the model exactly as it was, so the checker stays aligned with what a compliant memory would do.

The timing values it enforces are given on input ports in clock cycles: precharge-to-idle, activate-to-access, activate-to-activate across banks, the mode-register read and write windows, and the burst length. A burst occupies half the burst length in clock cycles. The verdict for the command presented in cycle n appears on `viol` and `viol_reason` in cycle n+1. The bank states it exposes are the states that the command presented in the same cycle is checked against.

Top module: `dram_cmd_legality`

## Requirements
- R1: Command codes on `cmd` are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, BURST-STOP=5, REFRESH=6, SELF-REFRESH=7, MODE-WRITE=8 and MODE-READ=9. Bank state i sits in `bank_state[3i+2:3i]` as Idle=0, RowActivating=1, Active=2, Read=3, Write=4 and Precharging=5. Reason codes are 0 none, 1 not all idle, 2 bad burst-stop, 3 activate spacing, 4 non-NOP in a protected window, 5 read/write turnaround and 6 bank in the wrong state. After reset every bank is Idle and `viol` and `viol_reason` are 0.
- R2: An ACTIVATE to an Idle bank makes it RowActivating until `t_rcd` cycles after the command and Active from then on. ACTIVATE to a bank that is not Idle, and READ or WRITE to a bank that is neither Active nor the bank owning the current burst, report reason 6.
- R3: PRECHARGE moves an Active bank to Precharging and then to Idle `t_rp` cycles after the command. With `all_banks` set it applies to every bank. It reports reason 6 when a targeted bank is RowActivating, Read or Write.
- R4: REFRESH, SELF-REFRESH and MODE-WRITE are rejected with reason 1 unless every bank is Idle. An accepted REFRESH or SELF-REFRESH leaves all bank states unchanged.
- R5: BURST-STOP is legal only while a burst is running and only when `bank` names the bank owning it; otherwise it reports reason 2. An accepted one returns that bank to Active in the next cycle.
- R6: An ACTIVATE to a bank other than the one last activated, fewer than `t_rrd` cycles after the last accepted ACTIVATE, reports reason 3.
- R7: After an accepted MODE-READ (MODE-WRITE), every command in the following `t_mrr`-1 (`t_mrw`-1) cycles must be NOP and otherwise reports reason 4. This reason takes priority over every other one. The cycle `t_mrr` (`t_mrw`) cycles after the command is unrestricted.
- R8: READ or WRITE puts the bank in Read or Write. The bank returns to Active by itself `burst_len`/2 cycles after the command.
- R9: A WRITE while a Read burst runs, or a READ while a Write burst runs, reports reason 5. A same-kind access to any Active bank is legal, ends the earlier burst and returns its bank to Active.
- R10: MODE-READ is accepted while banks are Idle, RowActivating, Active or Precharging. It reports reason 6 while a burst runs. Banks keep their states and timers through the window.
- R11: A command that reports a violation changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one command per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 4 | Decoded command code |
| bank | input | 3 | Target bank address |
| all_banks | input | 1 | PRECHARGE applies to every bank |
| t_rp | input | 8 | Precharge-to-idle time in cycles |
| t_rcd | input | 8 | Activate-to-access time in cycles |
| t_rrd | input | 8 | Minimum activate spacing across banks |
| t_mrr | input | 8 | Mode-read protected window in cycles |
| t_mrw | input | 8 | Mode-write protected window in cycles |
| burst_len | input | 8 | Burst length in data beats |
| bank_state | output | 24 | Packed per-bank state, three bits per bank |
| viol | output | 1 | One-cycle pulse for a rejected command |
| viol_reason | output | 3 | Reason for the rejection, 0 when none |

## Verification
A bank model that is off by one state or one timer tick shows on `bank_state` in the cycle the bank should have moved. It also shows one cycle later as a wrong verdict on the next command aimed at that bank: a READ flagged 6 too early, or a precharge-gated REFRESH accepted. A window counter that ends early or late shows as a wrong reason 4 on the first or last NOP-only cycle. Because rejected commands must freeze the model, a leak through the accept gate shows as a state change on the bank the rejected command targeted, visible in the next cycle.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_BST  = 4'd5,
    CMD_REF  = 4'd6,
    CMD_SREF = 4'd7,
    CMD_MRW  = 4'd8,
    CMD_MRR  = 4'd9
  } cmd_e;

  typedef enum logic [2:0] {
    BS_IDLE   = 3'd0,
    BS_ROWACT = 3'd1,
    BS_ACTIVE = 3'd2,
    BS_READ   = 3'd3,
    BS_WRITE  = 3'd4,
    BS_PRECH  = 3'd5
  } bstate_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_NOT_IDLE = 3'd1,
    RSN_BST      = 3'd2,
    RSN_RRD      = 3'd3,
    RSN_WINDOW   = 3'd4,
    RSN_TURN     = 3'd5,
    RSN_STATE    = 3'd6
  } reason_e;

  // Cycles a timed state is held: a span of t means the target state is
  // seen t cycles after the command; spans of 0 or 1 skip the wait state.
  function automatic logic span_direct(input logic [7:0] t);
    return t <= 8'd1;
  endfunction

  function automatic logic [7:0] span_load(input logic [7:0] t);
    return (t == 8'd0) ? 8'd0 : t - 8'd1;
  endfunction

  // Burst occupancy in clock cycles for a beat count (two beats per clock).
  function automatic logic [7:0] burst_cycles(input logic [7:0] beats);
    return beats >> 1;
  endfunction

endpackage

// File: rtl/dcl_bank.sv
module dcl_bank
  import dcl_pkg::*;
#(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            do_act,
  input  logic            do_rd,
  input  logic            do_wr,
  input  logic            do_pre,
  input  logic            do_stop,
  input  logic [CNTW-1:0] t_rcd,
  input  logic [CNTW-1:0] t_rp,
  input  logic [CNTW-1:0] burst_len,
  output logic [2:0]      st,
  output logic            in_burst
);

  bstate_e         cur, nxt;
  logic [CNTW-1:0] cnt, nxt_cnt;
  logic [CNTW-1:0] beat_span;
  logic            timer_done;

  assign beat_span  = burst_cycles(burst_len);
  assign timer_done = cnt <= 1;

  always_comb begin
    nxt     = cur;
    nxt_cnt = cnt;
    unique case (cur)
      BS_IDLE: begin
        if (do_act) begin
          if (span_direct(t_rcd)) nxt = BS_ACTIVE;
          else begin nxt = BS_ROWACT; nxt_cnt = span_load(t_rcd); end
        end
      end
      BS_ROWACT: begin
        if (timer_done) nxt = BS_ACTIVE;
        else nxt_cnt = cnt - 1'b1;
      end
      BS_PRECH: begin
        if (timer_done) nxt = BS_IDLE;
        else nxt_cnt = cnt - 1'b1;
      end
      BS_ACTIVE, BS_READ, BS_WRITE: begin
        if (do_rd || do_wr) begin
          if (span_direct(beat_span)) nxt = BS_ACTIVE;
          else begin
            nxt     = do_rd ? BS_READ : BS_WRITE;
            nxt_cnt = span_load(beat_span);
          end
        end else if (cur == BS_ACTIVE) begin
          if (do_pre) begin
            if (span_direct(t_rp)) nxt = BS_IDLE;
            else begin nxt = BS_PRECH; nxt_cnt = span_load(t_rp); end
          end
        end else if (do_stop || timer_done) begin
          nxt = BS_ACTIVE;
        end else begin
          nxt_cnt = cnt - 1'b1;
        end
      end
      default: nxt = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= BS_IDLE;
      cnt <= '0;
    end else begin
      cur <= nxt;
      cnt <= nxt_cnt;
    end
  end

  assign st       = cur;
  assign in_burst = (cur == BS_READ) || (cur == BS_WRITE);

  // R2: a row being opened only finishes opening
  assert_rowact_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cur == BS_ROWACT |=> (cur == BS_ROWACT || cur == BS_ACTIVE));

  // R3: a precharging bank only ever lands in Idle
  assert_prech_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cur == BS_PRECH |=> (cur == BS_PRECH || cur == BS_IDLE));

  // R8: without a new access a read burst stays or returns to Active
  assert_burst_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == BS_READ && !do_rd && !do_wr) |=> (cur == BS_READ || cur == BS_ACTIVE));

endmodule

// File: rtl/dcl_window.sv
module dcl_window
  import dcl_pkg::*;
#(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_mrr,
  input  logic            start_mrw,
  input  logic [CNTW-1:0] t_mrr,
  input  logic [CNTW-1:0] t_mrw,
  output logic            busy
);

  logic [CNTW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)         remain <= '0;
    else if (start_mrr) remain <= span_load(t_mrr);
    else if (start_mrw) remain <= span_load(t_mrw);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = remain != '0;

  // R7: a window can only be opened from outside a window
  assert_window_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(start_mrr || start_mrw));

endmodule

// File: rtl/dcl_rules.sv
module dcl_rules
  import dcl_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int CNTW  = 8,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic [3:0]            cmd,
  input  logic [BW-1:0]         bank,
  input  logic                  all_banks,
  input  logic [NBANK-1:0][2:0] st,
  input  logic                  win_busy,
  input  logic [CNTW-1:0]       act_gap,
  input  logic [BW-1:0]         last_act,
  input  logic [CNTW-1:0]       t_rrd,
  output logic [2:0]            reason
);

  logic all_idle, burst_rd, burst_wr, pre_bad_any;
  logic [2:0] tgt;

  assign tgt = st[bank];

  function automatic logic pre_blocked(input logic [2:0] s);
    return s == BS_ROWACT || s == BS_READ || s == BS_WRITE;
  endfunction

  always_comb begin
    all_idle    = 1'b1;
    burst_rd    = 1'b0;
    burst_wr    = 1'b0;
    pre_bad_any = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      if (st[i] != BS_IDLE)  all_idle    = 1'b0;
      if (st[i] == BS_READ)  burst_rd    = 1'b1;
      if (st[i] == BS_WRITE) burst_wr    = 1'b1;
      if (pre_blocked(st[i])) pre_bad_any = 1'b1;
    end
  end

  always_comb begin
    reason = RSN_NONE;
    if (win_busy && cmd != CMD_NOP) begin
      reason = RSN_WINDOW;
    end else begin
      case (cmd)
        CMD_ACT: begin
          if (tgt != BS_IDLE) reason = RSN_STATE;
          else if (bank != last_act && act_gap < t_rrd) reason = RSN_RRD;
        end
        CMD_RD, CMD_WR: begin
          if ((cmd == CMD_RD && burst_wr) || (cmd == CMD_WR && burst_rd))
            reason = RSN_TURN;
          else if (tgt != BS_ACTIVE && tgt != BS_READ && tgt != BS_WRITE)
            reason = RSN_STATE;
        end
        CMD_PRE: begin
          if (all_banks ? pre_bad_any : pre_blocked(tgt)) reason = RSN_STATE;
        end
        CMD_BST: begin
          if (tgt != BS_READ && tgt != BS_WRITE) reason = RSN_BST;
        end
        CMD_REF, CMD_SREF, CMD_MRW: begin
          if (!all_idle) reason = RSN_NOT_IDLE;
        end
        CMD_MRR: begin
          if (burst_rd || burst_wr) reason = RSN_STATE;
        end
        default: reason = RSN_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dram_cmd_legality.sv
module dram_cmd_legality
  import dcl_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int CNTW  = 8,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         cmd,
  input  logic [BW-1:0]      bank,
  input  logic               all_banks,
  input  logic [CNTW-1:0]    t_rp,
  input  logic [CNTW-1:0]    t_rcd,
  input  logic [CNTW-1:0]    t_rrd,
  input  logic [CNTW-1:0]    t_mrr,
  input  logic [CNTW-1:0]    t_mrw,
  input  logic [CNTW-1:0]    burst_len,
  output logic [NBANK*3-1:0] bank_state,
  output logic               viol,
  output logic [2:0]         viol_reason
);

  logic [NBANK-1:0][2:0] st;
  logic [NBANK-1:0]      burst_vec;
  logic [2:0]            reason;
  logic                  accept;
  logic                  win_busy;
  logic [CNTW-1:0]       act_gap;
  logic [BW-1:0]         last_act;
  logic                  acc_act, acc_rd, acc_wr, acc_pre, acc_bst;

  assign accept  = reason == RSN_NONE;
  assign acc_act = accept && cmd == CMD_ACT;
  assign acc_rd  = accept && cmd == CMD_RD;
  assign acc_wr  = accept && cmd == CMD_WR;
  assign acc_pre = accept && cmd == CMD_PRE;
  assign acc_bst = accept && cmd == CMD_BST;

  dcl_rules #(.NBANK(NBANK), .CNTW(CNTW)) u_rules (
    .cmd(cmd), .bank(bank), .all_banks(all_banks), .st(st),
    .win_busy(win_busy), .act_gap(act_gap), .last_act(last_act),
    .t_rrd(t_rrd), .reason(reason)
  );

  dcl_window #(.CNTW(CNTW)) u_window (
    .clk(clk), .rst_n(rst_n),
    .start_mrr(accept && cmd == CMD_MRR),
    .start_mrw(accept && cmd == CMD_MRW),
    .t_mrr(t_mrr), .t_mrw(t_mrw), .busy(win_busy)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic hit;
    assign hit = bank == BW'(i);
    dcl_bank #(.CNTW(CNTW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .do_act(acc_act && hit),
      .do_rd(acc_rd && hit),
      .do_wr(acc_wr && hit),
      .do_pre(acc_pre && (hit || all_banks)),
      .do_stop((acc_bst && hit) || ((acc_rd || acc_wr) && !hit)),
      .t_rcd(t_rcd), .t_rp(t_rp), .burst_len(burst_len),
      .st(st[i]), .in_burst(burst_vec[i])
    );
    assign bank_state[3*i +: 3] = st[i];
  end

  // Cycles since the last accepted ACTIVATE, saturating.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_gap  <= '1;
      last_act <= '0;
    end else if (acc_act) begin
      act_gap  <= CNTW'(1);
      last_act <= bank;
    end else if (act_gap != '1) begin
      act_gap  <= act_gap + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol        <= 1'b0;
      viol_reason <= RSN_NONE;
    end else begin
      viol        <= !accept;
      viol_reason <= reason;
    end
  end

  // R9: bursts never overlap across banks
  assert_single_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(burst_vec) <= 1);

  // R7: a non-NOP inside the window is flagged with the window reason
  assert_window_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_busy && cmd != CMD_NOP) |=> (viol && viol_reason == RSN_WINDOW));

  // R4: refresh-class commands only pass with every bank idle
  assert_refresh_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cmd == CMD_REF || cmd == CMD_SREF || cmd == CMD_MRW)) |-> (st == '0));

  // R5: an accepted burst-stop always hits the bank owning the burst
  assert_bst_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bst |-> burst_vec[bank]);

  // R11: a rejected ACTIVATE leaves an idle target idle
  assert_reject_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && cmd == CMD_ACT && st[bank] == BS_IDLE) |=> st[$past(bank)] == BS_IDLE);

endmodule

// File: tb/dram_cmd_legality_test.sv
module dram_cmd_legality_test;

  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, BST = 5,
                 REF = 6, SREF = 7, MRW = 8, MRR = 9;
  localparam int S_IDLE = 0, S_ROWACT = 1, S_ACTIVE = 2, S_READ = 3,
                 S_WRITE = 4, S_PRECH = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd = '0;
  logic [2:0]  bank = '0;
  logic        all_banks = 1'b0;
  logic [7:0]  t_rp = 8'd3, t_rcd = 8'd3, t_rrd = 8'd2;
  logic [7:0]  t_mrr = 8'd3, t_mrw = 8'd4, burst_len = 8'd8;
  logic [23:0] bank_state;
  logic        viol;
  logic [2:0]  viol_reason;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int due; int rsn; string tag; } exp_t;
  exp_t q[$];

  dram_cmd_legality uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .all_banks(all_banks),
    .t_rp(t_rp), .t_rcd(t_rcd), .t_rrd(t_rrd), .t_mrr(t_mrr), .t_mrw(t_mrw),
    .burst_len(burst_len), .bank_state(bank_state), .viol(viol),
    .viol_reason(viol_reason)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected end before 5000", cyc);
      report();
    end
  end

  // Monitor: compares the verdict for each command one cycle after it.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (viol !== (e.rsn != 0) || viol_reason !== 3'(e.rsn)) begin
        errors++;
        $display("FAIL %s: actual viol=%0b reason=%0d expected viol=%0b reason=%0d",
                 e.tag, viol, viol_reason, e.rsn != 0, e.rsn);
      end
    end
  end

  // Driver: one command per cycle, expected reason pushed for the monitor.
  task automatic issue(input int c, input int b, input bit all, input int rsn, input string tag);
    exp_t e;
    @(negedge clk);
    cmd = 4'(c); bank = 3'(b); all_banks = all;
    e.due = cyc + 1; e.rsn = rsn; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(NOP, 0, 1'b0, 0, "NOP");
  endtask

  // State seen by the command issued in the current cycle.
  task automatic see(input int b, input int s, input string tag);
    checks++;
    if (bank_state[3*b +: 3] !== 3'(s)) begin
      errors++;
      $display("FAIL %s: bank %0d actual state %0d expected %0d",
               tag, b, bank_state[3*b +: 3], s);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (bank_state !== 24'd0 || viol !== 1'b0 || viol_reason !== 3'd0) begin
      errors++;
      $display("FAIL R1 reset: actual state=%h viol=%0b reason=%0d expected 0 0 0",
               bank_state, viol, viol_reason);
    end

    issue(ACT, 0, 0, 0, "R2 activate idle bank");
    issue(ACT, 1, 0, 3, "R6 activate spacing");
    see(0, S_ROWACT, "R2 row activating");
    issue(RD, 0, 0, 6, "R2 read before tRCD");
    issue(ACT, 1, 0, 0, "R6 spacing met");
    see(0, S_ACTIVE, "R2 active at tRCD");
    see(1, S_IDLE, "R11 rejected activate left bank idle");
    issue(NOP, 0, 0, 0, "NOP");
    see(1, S_ROWACT, "R2 second bank opening");

    issue(RD, 0, 0, 0, "R8 read");
    issue(WR, 0, 0, 5, "R9 write during read");
    see(0, S_READ, "R8 read state");
    issue(BST, 1, 0, 2, "R5 stop to wrong bank");
    issue(NOP, 0, 0, 0, "NOP");
    see(0, S_READ, "R11 wrong-bank stop kept burst");
    issue(NOP, 0, 0, 0, "NOP");
    see(0, S_ACTIVE, "R8 burst auto end");

    issue(WR, 0, 0, 0, "R8 write");
    issue(BST, 0, 0, 0, "R5 stop owner");
    see(0, S_WRITE, "R8 write state");
    issue(BST, 0, 0, 2, "R5 stop with no burst");
    see(0, S_ACTIVE, "R5 stop returned to active");

    issue(RD, 0, 0, 0, "R8 read bank0");
    issue(RD, 1, 0, 0, "R9 read to other bank");
    issue(REF, 0, 0, 1, "R4 refresh with open banks");
    see(0, S_ACTIVE, "R9 earlier burst ended");
    see(1, S_READ, "R9 new burst owner");
    issue(PRE, 1, 0, 6, "R3 precharge during burst");
    issue(PRE, 0, 0, 0, "R3 precharge active");
    issue(MRR, 0, 0, 0, "R10 mode read");
    see(0, S_PRECH, "R3 precharging");
    see(1, S_ACTIVE, "R8 bank1 burst ended");
    issue(ACT, 2, 0, 4, "R7 activate in window");
    issue(RD, 1, 0, 4, "R7 read in window");
    issue(PRE, 0, 1, 0, "R3 precharge all");
    see(0, S_IDLE, "R3 idle after tRP");
    see(1, S_ACTIVE, "R10 state kept through window");
    issue(MRW, 0, 0, 1, "R4 mode write while precharging");
    see(1, S_PRECH, "R3 all-bank precharge");
    see(2, S_IDLE, "R7 rejected activate left bank idle");
    issue(NOP, 0, 0, 0, "NOP");
    issue(MRW, 0, 0, 0, "R4 mode write all idle");
    see(1, S_IDLE, "R3 all-bank idle");
    issue(REF, 0, 0, 4, "R7 refresh in write window");
    issue(NOP, 0, 0, 0, "R7 NOP in window");
    issue(NOP, 0, 0, 0, "R7 NOP in window");
    issue(SREF, 0, 0, 0, "R7 window over, self refresh");
    issue(REF, 0, 0, 0, "R4 refresh all idle");
    checks++;
    if (bank_state !== 24'd0) begin
      errors++;
      $display("FAIL R4 refresh changed state: actual %h expected 0", bank_state);
    end

    issue(ACT, 3, 0, 0, "R2 activate bank3");
    issue(ACT, 3, 0, 6, "R2 activate opening bank");
    issue(NOP, 0, 0, 0, "NOP");
    issue(RD, 3, 0, 0, "R8 read bank3");
    issue(MRR, 0, 0, 6, "R10 mode read during burst");
    issue(PRE, 3, 0, 6, "R3 precharge reading bank");
    see(3, S_READ, "R11 rejected commands kept burst");
    idle(3);
    report();
  end

endmodule